// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns single read or write requests from a processor core into external bus cycles on a time-shared pin set. Sixteen lines carry the low address and then the data. Four more lines carry the high address and then a status nibble. A byte-lane pin carries the upper-lane enable and then a status bit. Each request runs through the states T1, T2, T3, any number of wait states Tw, and T4. The block drives the strobes needed by an external address latch and a data transceiver. The core hands in the address, the byte enables, a memory-or-I/O flag, a write flag and the write data. It gets back a one-cycle completion pulse and, for reads, the captured data.

The sequencer also gives the bus away to another master through a request/grant handshake. It does this only when no bus cycle is running. While the grant is high, every address, data and control output is released. A lock input keeps the bus with the core by refusing new grants.

States and transitions: IDLE goes to T1 when a request is accepted. IDLE goes to HOLD when hold is high and lock is low, and this takes priority over a request. T1 goes to T2, and T2 goes to T3. T3 and TW go to T4 when ready is high and to TW when it is low. T4 goes to IDLE. HOLD goes to IDLE once hold is low.

Top module: `mux_bus_seq`

## Requirements
- R1: While reset is high, the block is in IDLE with ale=0, rd_n=1, wr_n=1, den_n=1, hlda=0, bus_oe=1, ad_oe=0, done=0 and bhe_n=1.
- R2: ale is 1 in T1 only. In T1, ad_out carries addr[15:0], a_hi carries addr[19:16], ad_oe=1, and bhe_n is the inverse of be[1] (be[1] selects the upper data lane).
- R3: From T2 through T4, a_hi carries the status nibble {0,0,mem,write}, with the write flag in bit 0 and the memory flag in bit 1, and bhe_n carries the status bit S7=1.
- R4: In a read, rd_n=0, wr_n=1 and den_n=0 in T2, T3 and every Tw, and dtr=0. ad_oe=0 from T2 through T4, and den_n returns to 1 in T4.
- R5: In a write, wr_n=0, rd_n=1 in T2, T3 and every Tw, and dtr=1. ad_oe=1 with ad_out equal to the write data, and den_n=0, from T2 through T4.
- R6: mio equals the request's memory flag (1 for memory, 0 for I/O) from T1 through T4.
- R7: ready is sampled on the clock edge that ends T3 and on the edge that ends each Tw. Each low sample inserts one Tw, so a cycle with N low samples lasts 4+N clocks.
- R8: For reads, rd_data takes ad_in on the edge where ready is sampled high. done is 1 for exactly the T4 cycle.
- R9: A hold request is granted only from IDLE. hlda rises on the clock after IDLE sees hold=1 with lock=0. A hold raised mid-cycle waits until the cycle has ended and the block has spent one cycle in IDLE.
- R10: While hlda=1, bus_oe=0, ad_oe=0, ale=0 and req_accept=0. hlda falls on the clock after hold is seen low.
- R11: While lock=1, hold is not granted and requests keep being accepted.
- R12: req_accept is 1 only in IDLE, and only when no grant is due. At least one IDLE cycle separates consecutive bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_addr | input | 20 | Request address |
| req_be | input | 2 | Byte-lane enables, bit 1 = upper lane |
| req_wdata | input | 16 | Write data |
| req_accept | output | 1 | Request is taken on this edge when valid |
| done | output | 1 | Cycle completes (T4) |
| rd_data | output | 16 | Captured read data |
| ad_out | output | 16 | Low address / data lines, outgoing value |
| ad_in | input | 16 | Low address / data lines, incoming value |
| ad_oe | output | 1 | Drive enable for the address/data lines |
| a_hi | output | 4 | High address in T1, status afterwards |
| bhe_n | output | 1 | Upper lane enable in T1, S7 afterwards |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| dtr | output | 1 | Transceiver direction, 1 = outgoing |
| mio | output | 1 | 1 = memory, 0 = I/O |
| bus_oe | output | 1 | Drive enable for a_hi, bhe_n and control pins |
| ready | input | 1 | Device ready |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus grant |
| lock | input | 1 | Suppresses bus grants |

## Verification
The assertions assume that ready, hold and lock change only between clock edges, away from the sampling edge. They also assume that ad_in is settled on the edge where ready is seen high. They make no assumption about how long hold or lock stay high.

The bench drives every input at the falling edge. It raises ready only on the cycle meant to end the waits, and before that edge it holds ad_in at a deliberately wrong value. A wrong capture point therefore shows up in rd_data. Hold is raised either in IDLE, in the middle of a cycle, or under lock, which are the three situations the grant logic distinguishes.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_TW,
        ST_T4,
        ST_HOLD
    } bus_state_e;
endpackage

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
    import mbs_pkg::*;
#(
    parameter int AW  = 20,
    parameter int DW  = 16,
    parameter int BEW = DW / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_mem,
    input  logic [AW-1:0]    req_addr,
    input  logic [BEW-1:0]   req_be,
    input  logic [DW-1:0]    req_wdata,
    input  logic             ready,
    input  logic             hold,
    input  logic             lock,
    input  logic [DW-1:0]    ad_in,
    output bus_state_e       state,
    output logic             cur_write,
    output logic             cur_mem,
    output logic [AW-1:0]    cur_addr,
    output logic [BEW-1:0]   cur_be,
    output logic [DW-1:0]    cur_wdata,
    output logic [DW-1:0]    rd_data,
    output logic             req_accept
);
    bus_state_e nxt;
    logic       grant_due;
    logic       take_req;

    assign grant_due  = hold && !lock;
    assign req_accept = (state == ST_IDLE) && !grant_due;
    assign take_req   = req_valid && req_accept;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (grant_due)     nxt = ST_HOLD;
                else if (req_valid) nxt = ST_T1;
            end
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3:   nxt = ready ? ST_T4 : ST_TW;
            ST_TW:   nxt = ready ? ST_T4 : ST_TW;
            ST_T4:   nxt = ST_IDLE;
            ST_HOLD: nxt = hold ? ST_HOLD : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_write <= 1'b0;
            cur_mem   <= 1'b0;
            cur_addr  <= '0;
            cur_be    <= '0;
            cur_wdata <= '0;
            rd_data   <= '0;
        end else begin
            if (take_req) begin
                cur_write <= req_write;
                cur_mem   <= req_mem;
                cur_addr  <= req_addr;
                cur_be    <= req_be;
                cur_wdata <= req_wdata;
            end
            if ((state == ST_T3 || state == ST_TW) && ready && !cur_write)
                rd_data <= ad_in;
        end
    end
endmodule

// File: rtl/mbs_pins.sv
module mbs_pins
    import mbs_pkg::*;
#(
    parameter int AW  = 20,
    parameter int DW  = 16,
    parameter int BEW = DW / 8
) (
    input  bus_state_e       state,
    input  logic             cur_write,
    input  logic             cur_mem,
    input  logic [AW-1:0]    cur_addr,
    input  logic [BEW-1:0]   cur_be,
    input  logic [DW-1:0]    cur_wdata,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    output logic [AW-DW-1:0] a_hi,
    output logic             bhe_n,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             den_n,
    output logic             dtr,
    output logic             mio,
    output logic             bus_oe,
    output logic             hlda,
    output logic             done
);
    localparam int HIW = AW - DW;

    logic [HIW-1:0] status_nib;
    assign status_nib = {{(HIW-2){1'b0}}, cur_mem, cur_write};

    always_comb begin
        ale    = 1'b0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        den_n  = 1'b1;
        ad_oe  = 1'b0;
        ad_out = '0;
        a_hi   = status_nib;
        bhe_n  = 1'b1;
        bus_oe = 1'b1;
        hlda   = 1'b0;
        done   = 1'b0;
        dtr    = cur_write;
        mio    = cur_mem;
        unique case (state)
            ST_IDLE: ;
            ST_T1: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = cur_addr[DW-1:0];
                a_hi   = cur_addr[AW-1:DW];
                bhe_n  = ~cur_be[BEW-1];
            end
            ST_T2, ST_T3, ST_TW: begin
                den_n = 1'b0;
                if (cur_write) begin
                    wr_n   = 1'b0;
                    ad_oe  = 1'b1;
                    ad_out = cur_wdata;
                end else begin
                    rd_n = 1'b0;
                end
            end
            ST_T4: begin
                done = 1'b1;
                if (cur_write) begin
                    den_n  = 1'b0;
                    ad_oe  = 1'b1;
                    ad_out = cur_wdata;
                end
            end
            ST_HOLD: begin
                bus_oe = 1'b0;
                hlda   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mbs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_mem,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW/8-1:0]  req_be,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_accept,
    output logic             done,
    output logic [DW-1:0]    rd_data,
    output logic [DW-1:0]    ad_out,
    input  logic [DW-1:0]    ad_in,
    output logic             ad_oe,
    output logic [AW-DW-1:0] a_hi,
    output logic             bhe_n,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             den_n,
    output logic             dtr,
    output logic             mio,
    output logic             bus_oe,
    input  logic             ready,
    input  logic             hold,
    output logic             hlda,
    input  logic             lock
);
    localparam int BEW = DW / 8;

    bus_state_e       state;
    logic             cur_write;
    logic             cur_mem;
    logic [AW-1:0]    cur_addr;
    logic [BEW-1:0]   cur_be;
    logic [DW-1:0]    cur_wdata;

    mbs_ctrl #(.AW(AW), .DW(DW), .BEW(BEW)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_mem    (req_mem),
        .req_addr   (req_addr),
        .req_be     (req_be),
        .req_wdata  (req_wdata),
        .ready      (ready),
        .hold       (hold),
        .lock       (lock),
        .ad_in      (ad_in),
        .state      (state),
        .cur_write  (cur_write),
        .cur_mem    (cur_mem),
        .cur_addr   (cur_addr),
        .cur_be     (cur_be),
        .cur_wdata  (cur_wdata),
        .rd_data    (rd_data),
        .req_accept (req_accept)
    );

    mbs_pins #(.AW(AW), .DW(DW), .BEW(BEW)) pins_i (
        .state     (state),
        .cur_write (cur_write),
        .cur_mem   (cur_mem),
        .cur_addr  (cur_addr),
        .cur_be    (cur_be),
        .cur_wdata (cur_wdata),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .a_hi      (a_hi),
        .bhe_n     (bhe_n),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .den_n     (den_n),
        .dtr       (dtr),
        .mio       (mio),
        .bus_oe    (bus_oe),
        .hlda      (hlda),
        .done      (done)
    );
endmodule

// File: rtl/mbs_chk.sv
module mbs_chk (
    input logic clk,
    input logic rst,
    input logic req_accept,
    input logic done,
    input logic ad_oe,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic den_n,
    input logic dtr,
    input logic bus_oe,
    input logic hold,
    input logic hlda,
    input logic lock
);
    p_ale_single_r2: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    p_ale_drives_r2: assert property (@(posedge clk) disable iff (rst)
        ale |-> (ad_oe && bus_oe));

    p_read_float_r4: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> (!ad_oe && wr_n && !dtr && !den_n));

    p_write_drive_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> (ad_oe && dtr && !den_n));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_grant_idle_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(hlda) |-> ($past(den_n) && !$past(ale) && $past(rd_n) && $past(wr_n)));

    p_hold_float_r10: assert property (@(posedge clk) disable iff (rst)
        hlda |-> (!bus_oe && !ad_oe && !ale && !req_accept));

    p_hold_release_r10: assert property (@(posedge clk) disable iff (rst)
        (hlda && !hold) |=> !hlda);

    p_lock_blocks_r11: assert property (@(posedge clk) disable iff (rst)
        (lock && !hlda) |=> !hlda);

    p_accept_gap_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_accept);
endmodule

bind mux_bus_seq mbs_chk chk_i (.*);

// File: tb/mux_bus_seq_tb_top.sv
module mux_bus_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_mem;
    logic [19:0] req_addr;
    logic [1:0]  req_be;
    logic [15:0] req_wdata;
    logic        req_accept, done;
    logic [15:0] rd_data, ad_out, ad_in;
    logic        ad_oe;
    logic [3:0]  a_hi;
    logic        bhe_n, ale, rd_n, wr_n, den_n, dtr, mio, bus_oe;
    logic        ready, hold, hlda, lock;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    mux_bus_seq dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_mem(req_mem), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .req_accept(req_accept), .done(done),
        .rd_data(rd_data), .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe),
        .a_hi(a_hi), .bhe_n(bhe_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .den_n(den_n), .dtr(dtr), .mio(mio), .bus_oe(bus_oe), .ready(ready),
        .hold(hold), .hlda(hlda), .lock(lock)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_mid(input bit wr, input bit mem, input logic [3:0] st, input logic [15:0] wd);
        chk(ale == 1'b0, "R2 ale low after T1", 32'(ale), 0);
        chk(a_hi == st, "R3 status nibble", 32'(a_hi), 32'(st));
        chk(bhe_n == 1'b1, "R3 S7 high", 32'(bhe_n), 1);
        chk(mio == mem, "R6 mio", 32'(mio), 32'(mem));
        chk(done == 1'b0, "R7 no done before T4", 32'(done), 0);
        chk(hlda == 1'b0, "R9 no grant mid-cycle", 32'(hlda), 0);
        chk(den_n == 1'b0, "R4 R5 den_n low", 32'(den_n), 0);
        chk(dtr == wr, "R4 R5 dtr", 32'(dtr), 32'(wr));
        if (wr) begin
            chk(wr_n == 1'b0 && rd_n == 1'b1, "R5 write strobe", {30'd0, wr_n, rd_n}, 32'b01);
            chk(ad_oe == 1'b1 && ad_out == wd, "R5 write data", {15'd0, ad_oe, ad_out}, {15'd0, 1'b1, wd});
        end else begin
            chk(rd_n == 1'b0 && wr_n == 1'b1, "R4 read strobe", {30'd0, rd_n, wr_n}, 32'b01);
            chk(ad_oe == 1'b0, "R4 bus floats in read", 32'(ad_oe), 0);
        end
    endtask

    task automatic do_cycle(input bit wr, input bit mem, input logic [19:0] addr,
                            input logic [1:0] be, input logic [15:0] wd,
                            input logic [15:0] rdv, input int nw, input bit hold_mid);
        logic [3:0] st;
        st = {2'b00, mem, wr};
        chk(req_accept == 1'b1, "R12 accept in idle", 32'(req_accept), 1);
        req_valid = 1'b1; req_write = wr; req_mem = mem;
        req_addr = addr; req_be = be; req_wdata = wd;
        step();
        req_valid = 1'b0;
        // T1
        chk(ale == 1'b1, "R2 ale in T1", 32'(ale), 1);
        chk(ad_oe == 1'b1 && ad_out == addr[15:0], "R2 low address", {15'd0, ad_oe, ad_out}, {15'd0, 1'b1, addr[15:0]});
        chk(a_hi == addr[19:16], "R2 high address", 32'(a_hi), 32'(addr[19:16]));
        chk(bhe_n == ~be[1], "R2 bhe_n", 32'(bhe_n), 32'(~be[1]));
        chk(mio == mem, "R6 mio in T1", 32'(mio), 32'(mem));
        chk(rd_n == 1'b1 && wr_n == 1'b1, "R4 R5 no strobe in T1", {30'd0, rd_n, wr_n}, 32'b11);
        chk(req_accept == 1'b0, "R12 no accept in T1", 32'(req_accept), 0);
        step();
        // T2
        if (hold_mid) hold = 1'b1;
        chk_mid(wr, mem, st, wd);
        step();
        // T3
        chk_mid(wr, mem, st, wd);
        ready = (nw == 0);
        ad_in = (nw == 0) ? rdv : ~rdv;
        for (int i = 0; i < nw; i++) begin
            step();
            chk_mid(wr, mem, st, wd);
            ready = (i == nw - 1);
            ad_in = (i == nw - 1) ? rdv : ~rdv;
        end
        step();
        // T4
        chk(done == 1'b1, "R7 R8 done in T4 after waits", 32'(done), 1);
        chk(a_hi == st && bhe_n == 1'b1, "R3 status in T4", {27'd0, bhe_n, a_hi}, {27'd0, 1'b1, st});
        chk(hlda == 1'b0, "R9 no grant in T4", 32'(hlda), 0);
        if (wr) begin
            chk(ad_oe == 1'b1 && ad_out == wd && den_n == 1'b0, "R5 T4 write drive", {14'd0, den_n, ad_oe, ad_out}, {14'd0, 1'b0, 1'b1, wd});
            chk(wr_n == 1'b1, "R5 wr_n ends", 32'(wr_n), 1);
        end else begin
            chk(rd_data == rdv, "R8 read capture", 32'(rd_data), 32'(rdv));
            chk(ad_oe == 1'b0 && den_n == 1'b1 && rd_n == 1'b1, "R4 T4 read", {29'd0, ad_oe, den_n, rd_n}, 32'b011);
        end
        ready = 1'b1;
        step();
        // IDLE
        chk(done == 1'b0, "R8 done single cycle", 32'(done), 0);
        chk(ale == 1'b0 && hlda == 1'b0, "R9 idle before grant", {30'd0, ale, hlda}, 0);
        chk(req_accept == !hold_mid, "R12 accept after cycle", 32'(req_accept), 32'(!hold_mid));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int idx;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_mem = 1'b0;
        req_addr = '0; req_be = '0; req_wdata = '0; ad_in = '0;
        ready = 1'b1; hold = 1'b0; lock = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ale == 0 && rd_n == 1 && wr_n == 1 && den_n == 1, "R1 strobes idle", {28'd0, ale, rd_n, wr_n, den_n}, 32'b0111);
        chk(hlda == 0 && bus_oe == 1 && ad_oe == 0, "R1 enables", {29'd0, hlda, bus_oe, ad_oe}, 32'b010);
        chk(done == 0 && bhe_n == 1, "R1 done and bhe_n", {30'd0, done, bhe_n}, 32'b01);
        rst = 1'b0;
        step();

        idx = 0;
        for (int w = 0; w < 2; w++)
            for (int m = 0; m < 2; m++)
                for (int b = 1; b < 4; b++)
                    for (int nw = 0; nw < 4; nw++) begin
                        do_cycle(w[0], m[0], 20'h0A5C3 + 20'(idx) * 20'h2F1B3, b[1:0],
                                 16'hC3A5 ^ 16'(idx * 16'h1111), 16'h5AA5 + 16'(idx * 16'h0707),
                                 nw, 1'b0);
                        idx++;
                    end

        // grant from idle, requests ignored during hold
        hold = 1'b1; req_valid = 1'b1; req_write = 1'b1;
        step();
        chk(hlda == 1'b1, "R9 grant from idle", 32'(hlda), 1);
        for (int k = 0; k < 3; k++) begin
            chk(bus_oe == 0 && ad_oe == 0 && ale == 0, "R10 outputs released", {29'd0, bus_oe, ad_oe, ale}, 0);
            chk(req_accept == 1'b0, "R10 no accept in hold", 32'(req_accept), 0);
            step();
        end
        req_valid = 1'b0;
        hold = 1'b0;
        step();
        chk(hlda == 1'b0 && ale == 1'b0, "R10 grant drops, no cycle ran", {30'd0, hlda, ale}, 0);

        // hold raised mid-cycle
        do_cycle(1'b0, 1'b1, 20'h3C0F0, 2'b11, 16'h0, 16'hBEEF, 1, 1'b1);
        step();
        chk(hlda == 1'b1, "R9 grant after cycle", 32'(hlda), 1);
        hold = 1'b0;
        step();
        chk(hlda == 1'b0, "R10 release", 32'(hlda), 0);

        // lock suppresses grant
        lock = 1'b1; hold = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step();
            chk(hlda == 1'b0 && req_accept == 1'b1, "R11 locked, no grant", {30'd0, hlda, req_accept}, 32'b01);
        end
        do_cycle(1'b1, 1'b0, 20'hF00F1, 2'b01, 16'h1234, 16'h0, 2, 1'b0);
        chk(hlda == 1'b0, "R11 still no grant", 32'(hlda), 0);
        lock = 1'b0;
        step();
        chk(hlda == 1'b1, "R11 grant after unlock", 32'(hlda), 1);
        hold = 1'b0;
        step();
        chk(hlda == 1'b0, "R10 final release", 32'(hlda), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule